// File: doc/BRIEF.md
# Windowed Frame Buffer Write Address Generator

This block sits between a host command port and a pixel memory. The host selects a register with an index command, then streams configuration bytes. The index steps by one after every byte, so one index command followed by thirteen bytes loads the whole setup. The setup has five parts:

- the left and right column limits of a rectangle
- the top and bottom row limits of that rectangle
- the line stride, meaning the memory words per image row
- an 18-bit base address
- a pixel-write mode that two command codes switch on and off

While pixel-write mode is on, every pixel strobe produces one memory write. The address of that write is base + row * stride + column. The column and row come from a cursor that sweeps the rectangle in raster order, so the host never supplies a pixel address. The cursor returns to the left column at the end of each row and to the top row after the bottom row. The memory has up to 640x240 words of 18 bits. The memory itself, reading and rotation belong to other blocks.

Top module: `fbag_addr_gen`

## Requirements
- R1: After reset the limits are: column start 0, column end 319, row start 0, row end 239. The stride is 320, the base is 0 and pixel-write mode is off. `ram_we` is low.
- R2: Command byte values other than 0xC1 and 0x80 set the register index. Each data byte is written to the register at the current index, and the index then advances by one.
- R3: Register indices hold the following fields:
  - 0x00 and 0x01: column start, high bits and low byte.
  - 0x02 and 0x03: column end, high bits and low byte.
  - 0x04 and 0x05: row start, high bits and low byte.
  - 0x06 and 0x07: row end, high bits and low byte.
  - 0x08 and 0x09: stride, high bits and low byte.
  - 0x0A, 0x0B and 0x0C: base address bits 17:16, 15:8 and 7:0.
  - A high byte uses only its bits 1:0 at the default widths.
- R4: Each accepted pixel moves the cursor one column to the right. After the column end, the column returns to the column start and the row advances by one. End limits are inclusive.
- R5: After an accepted pixel at the row end and the column end, the row returns to the row start.
- R6: The write address is (base + row * stride + column) modulo 2^18.
- R7: Command 0xC1 turns pixel-write mode on and moves the cursor to the column start and row start.
- R8: Command 0x80 turns pixel-write mode off. A pixel strobe while the mode is off produces no memory write.
- R9: An accepted strobe drives `ram_we` high for exactly one cycle, one clock after the strobe, with `ram_wdata` equal to the strobed pixel.
- R10: A data byte at an index above 0x0C changes no field. The index still advances and wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Register index, or the mode code 0xC1 / 0x80 |
| data_valid | input | 1 | Register data byte strobe |
| data_byte | input | 8 | Register data byte |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | 18 | Pixel value |
| ram_we | output | 1 | Memory write enable |
| ram_addr | output | 18 | Memory write address |
| ram_wdata | output | 18 | Memory write data |

## Verification
Command and register bytes take effect at the clock edge that samples them, so the very next strobe already uses the new setting. A pixel result appears at the memory port on the clock edge after its strobe. Inputs are driven on the falling edge, so each write is checked at the falling edge that follows its strobe. At that point `ram_we`, `ram_addr` and `ram_wdata` are stable and compared with a bench model of the cursor. The same falling edge also shows `ram_we` low after an ignored strobe. Window sweeps cover several shapes over two full passes, which exercises the row and column wraps and the base-address wrap modulo 2^18.

// File: rtl/fbag_pkg.sv
`timescale 1ns/1ps
package fbag_pkg;
   // register indices: the host addresses these, so the numbering is fixed
   localparam logic [7:0] IDX_XS_HI = 8'h00;
   localparam logic [7:0] IDX_XS_LO = 8'h01;
   localparam logic [7:0] IDX_XE_HI = 8'h02;
   localparam logic [7:0] IDX_XE_LO = 8'h03;
   localparam logic [7:0] IDX_YS_HI = 8'h04;
   localparam logic [7:0] IDX_YS_LO = 8'h05;
   localparam logic [7:0] IDX_YE_HI = 8'h06;
   localparam logic [7:0] IDX_YE_LO = 8'h07;
   localparam logic [7:0] IDX_ST_HI = 8'h08;
   localparam logic [7:0] IDX_ST_LO = 8'h09;
   localparam logic [7:0] IDX_BA_2  = 8'h0A;
   localparam logic [7:0] IDX_BA_1  = 8'h0B;
   localparam logic [7:0] IDX_BA_0  = 8'h0C;

   // mode command codes
   localparam logic [7:0] CODE_PIX_ON  = 8'hC1;
   localparam logic [7:0] CODE_PIX_OFF = 8'h80;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_INDEX  = 2'd1,
      CMD_PIX_ON = 2'd2,
      CMD_PIXOFF = 2'd3
   } cmd_kind_e;

   function automatic cmd_kind_e decode_cmd(input logic valid, input logic [7:0] code);
      if (!valid)                     return CMD_NONE;
      else if (code == CODE_PIX_ON)   return CMD_PIX_ON;
      else if (code == CODE_PIX_OFF)  return CMD_PIXOFF;
      else                            return CMD_INDEX;
   endfunction
endpackage

// File: rtl/fbag_regfile.sv
`timescale 1ns/1ps
module fbag_regfile
   import fbag_pkg::*;
#(
   parameter int COORD_W   = 10,
   parameter int STRIDE_W  = 10,
   parameter int ADDR_W    = 18,
   parameter int RST_X_END = 319,
   parameter int RST_Y_END = 239,
   parameter int RST_STRD  = 320
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [7:0]          cmd_byte,
   input  logic                data_valid,
   input  logic [7:0]          data_byte,
   output logic [COORD_W-1:0]  x_start,
   output logic [COORD_W-1:0]  x_end,
   output logic [COORD_W-1:0]  y_start,
   output logic [COORD_W-1:0]  y_end,
   output logic [STRIDE_W-1:0] stride,
   output logic [ADDR_W-1:0]   base,
   output logic                pix_mode,
   output logic                cursor_home
);
   localparam int XH_W = COORD_W - 8;
   localparam int SH_W = STRIDE_W - 8;
   localparam int AH_W = ADDR_W - 16;

   cmd_kind_e kind;
   logic [7:0] idx_q;

   assign kind        = decode_cmd(cmd_valid, cmd_byte);
   assign cursor_home = (kind == CMD_PIX_ON);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q    <= '0;
         pix_mode <= 1'b0;
      end else begin
         case (kind)
            CMD_PIX_ON: pix_mode <= 1'b1;
            CMD_PIXOFF: pix_mode <= 1'b0;
            CMD_INDEX:  idx_q    <= cmd_byte;
            default: ;
         endcase
         if (data_valid && kind != CMD_INDEX)
            idx_q <= idx_q + 8'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_start <= '0;
         x_end   <= COORD_W'(RST_X_END);
         y_start <= '0;
         y_end   <= COORD_W'(RST_Y_END);
         stride  <= STRIDE_W'(RST_STRD);
         base    <= '0;
      end else if (data_valid) begin
         case (idx_q)
            IDX_XS_HI: x_start[COORD_W-1:8] <= data_byte[XH_W-1:0];
            IDX_XS_LO: x_start[7:0]         <= data_byte;
            IDX_XE_HI: x_end[COORD_W-1:8]   <= data_byte[XH_W-1:0];
            IDX_XE_LO: x_end[7:0]           <= data_byte;
            IDX_YS_HI: y_start[COORD_W-1:8] <= data_byte[XH_W-1:0];
            IDX_YS_LO: y_start[7:0]         <= data_byte;
            IDX_YE_HI: y_end[COORD_W-1:8]   <= data_byte[XH_W-1:0];
            IDX_YE_LO: y_end[7:0]           <= data_byte;
            IDX_ST_HI: stride[STRIDE_W-1:8] <= data_byte[SH_W-1:0];
            IDX_ST_LO: stride[7:0]          <= data_byte;
            IDX_BA_2:  base[ADDR_W-1:16]    <= data_byte[AH_W-1:0];
            IDX_BA_1:  base[15:8]           <= data_byte;
            IDX_BA_0:  base[7:0]            <= data_byte;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fbag_cursor.sv
`timescale 1ns/1ps
module fbag_cursor #(
   parameter int COORD_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               home,
   input  logic               step,
   input  logic [COORD_W-1:0] x_start,
   input  logic [COORD_W-1:0] x_end,
   input  logic [COORD_W-1:0] y_start,
   input  logic [COORD_W-1:0] y_end,
   output logic [COORD_W-1:0] cur_x,
   output logic [COORD_W-1:0] cur_y
);
   logic row_done, frame_done;

   // >= keeps a window with start beyond end from running off the row
   assign row_done   = (cur_x >= x_end);
   assign frame_done = (cur_y >= y_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_x <= '0;
         cur_y <= '0;
      end else if (home) begin
         cur_x <= x_start;
         cur_y <= y_start;
      end else if (step) begin
         if (row_done) begin
            cur_x <= x_start;
            cur_y <= frame_done ? y_start : cur_y + COORD_W'(1);
         end else begin
            cur_x <= cur_x + COORD_W'(1);
         end
      end
   end
endmodule

// File: rtl/fbag_addr.sv
`timescale 1ns/1ps
module fbag_addr #(
   parameter int COORD_W  = 10,
   parameter int STRIDE_W = 10,
   parameter int ADDR_W   = 18,
   parameter int PIX_W    = 18,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic [COORD_W-1:0]  cur_x,
   input  logic [COORD_W-1:0]  cur_y,
   input  logic [STRIDE_W-1:0] stride,
   input  logic [ADDR_W-1:0]   base,
   input  logic [PIX_W-1:0]    pix_data,
   output logic                ram_we,
   output logic [ADDR_W-1:0]   ram_addr,
   output logic [PIX_W-1:0]    ram_wdata
);
   logic [ADDR_W-1:0] addr_c;

   // modulo 2^ADDR_W arithmetic: every operand sized to the address width
   assign addr_c = base
                 + ADDR_W'(ADDR_W'(cur_y) * ADDR_W'(stride))
                 + ADDR_W'(cur_x);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ram_we    <= 1'b0;
               ram_addr  <= '0;
               ram_wdata <= '0;
            end else begin
               ram_we <= accept;
               if (accept) begin
                  ram_addr  <= addr_c;
                  ram_wdata <= pix_data;
               end
            end
         end
      end else begin : g_comb
         assign ram_we    = accept;
         assign ram_addr  = addr_c;
         assign ram_wdata = pix_data;
      end
   endgenerate
endmodule

// File: rtl/fbag_addr_gen.sv
`timescale 1ns/1ps
module fbag_addr_gen #(
   parameter int COORD_W   = 10,
   parameter int STRIDE_W  = 10,
   parameter int ADDR_W    = 18,
   parameter int PIX_W     = 18,
   parameter int RST_X_END = 319,
   parameter int RST_Y_END = 239,
   parameter int RST_STRD  = 320,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_byte,
   input  logic              data_valid,
   input  logic [7:0]        data_byte,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_data,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [PIX_W-1:0]  ram_wdata
);
   generate
      if (COORD_W < 9 || COORD_W > 16) begin : g_bad_coord
         $error("COORD_W must lie in 9..16");
      end
      if (STRIDE_W < 9 || STRIDE_W > 16) begin : g_bad_stride
         $error("STRIDE_W must lie in 9..16");
      end
      if (ADDR_W < 17 || ADDR_W > 24) begin : g_bad_addr
         $error("ADDR_W must lie in 17..24");
      end
   endgenerate

   logic [COORD_W-1:0]  x_start, x_end, y_start, y_end, cur_x, cur_y;
   logic [STRIDE_W-1:0] stride;
   logic [ADDR_W-1:0]   base;
   logic                wr_en, home, accept;

   assign accept = pix_valid && wr_en;

   fbag_regfile #(
      .COORD_W(COORD_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W),
      .RST_X_END(RST_X_END), .RST_Y_END(RST_Y_END), .RST_STRD(RST_STRD)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .data_valid(data_valid), .data_byte(data_byte),
      .x_start(x_start), .x_end(x_end), .y_start(y_start), .y_end(y_end),
      .stride(stride), .base(base),
      .pix_mode(wr_en), .cursor_home(home)
   );

   fbag_cursor #(.COORD_W(COORD_W)) u_cursor (
      .clk(clk), .rst_n(rst_n), .home(home), .step(accept),
      .x_start(x_start), .x_end(x_end), .y_start(y_start), .y_end(y_end),
      .cur_x(cur_x), .cur_y(cur_y)
   );

   fbag_addr #(
      .COORD_W(COORD_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W),
      .PIX_W(PIX_W), .OUT_REG(OUT_REG)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .cur_x(cur_x), .cur_y(cur_y), .stride(stride), .base(base),
      .pix_data(pix_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
   );
endmodule

// File: rtl/fbag_chk.sv
`timescale 1ns/1ps
module fbag_chk #(
   parameter int COORD_W = 10,
   parameter bit OUT_REG = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic [7:0]         cmd_byte,
   input logic               pix_valid,
   input logic               wr_en,
   input logic               ram_we,
   input logic [COORD_W-1:0] cur_x,
   input logic [COORD_W-1:0] cur_y,
   input logic [COORD_W-1:0] x_start,
   input logic [COORD_W-1:0] x_end,
   input logic [COORD_W-1:0] y_start,
   input logic [COORD_W-1:0] y_end
);
   logic go_home, acc;
   assign go_home = cmd_valid && (cmd_byte == 8'hC1);
   assign acc     = pix_valid && wr_en;

   // R4
   col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !go_home && cur_x < x_end) |=> cur_x == $past(cur_x) + COORD_W'(1));

   // R5
   row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !go_home && cur_x >= x_end && cur_y >= y_end) |=> cur_y == $past(y_start));

   // R7
   home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_home |=> (cur_x == $past(x_start) && cur_y == $past(y_start)));

   // R8
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte == 8'h80) |=> !wr_en);

   generate
      if (OUT_REG) begin : g_lat
         // R8
         ignored_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && !wr_en) |=> !ram_we);
         // R9
         we_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ram_we |-> $past(pix_valid && wr_en));
      end
   endgenerate
endmodule

bind fbag_addr_gen fbag_chk #(.COORD_W(COORD_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
   .pix_valid(pix_valid), .wr_en(wr_en), .ram_we(ram_we),
   .cur_x(cur_x), .cur_y(cur_y),
   .x_start(x_start), .x_end(x_end), .y_start(y_start), .y_end(y_end)
);

// File: tb/test_fbag_addr_gen.sv
`timescale 1ns/1ps
module test_fbag_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, data_valid = 1'b0, pix_valid = 1'b0;
   logic [7:0]  cmd_byte = '0, data_byte = '0;
   logic [17:0] pix_data = '0;
   logic        ram_we;
   logic [17:0] ram_addr, ram_wdata;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model of the programmed setup and cursor
   int m_xs = 0, m_xe = 319, m_ys = 0, m_ye = 239, m_st = 320, m_ba = 0;
   int m_x = 0, m_y = 0, m_idx = 0;
   bit m_en = 0;

   always #2.5 clk = ~clk;

   fbag_addr_gen i_fbag_addr_gen (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .data_valid(data_valid), .data_byte(data_byte),
      .pix_valid(pix_valid), .pix_data(pix_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   function automatic int hi2(input int b);
      return (b & 3) << 8;
   endfunction

   task automatic model_byte(input int idx, input int b);
      case (idx)
         0:  m_xs = (m_xs & 'hFF) | hi2(b);
         1:  m_xs = (m_xs & 'h300) | b;
         2:  m_xe = (m_xe & 'hFF) | hi2(b);
         3:  m_xe = (m_xe & 'h300) | b;
         4:  m_ys = (m_ys & 'hFF) | hi2(b);
         5:  m_ys = (m_ys & 'h300) | b;
         6:  m_ye = (m_ye & 'hFF) | hi2(b);
         7:  m_ye = (m_ye & 'h300) | b;
         8:  m_st = (m_st & 'hFF) | hi2(b);
         9:  m_st = (m_st & 'h300) | b;
         10: m_ba = (m_ba & 'hFFFF) | ((b & 3) << 16);
         11: m_ba = (m_ba & 'h300FF) | (b << 8);
         12: m_ba = (m_ba & 'h3FF00) | b;
         default: ;
      endcase
   endtask

   task automatic send_cmd(input int c);
      cmd_valid = 1'b1; cmd_byte = 8'(c);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (c == 'hC1) begin m_en = 1; m_x = m_xs; m_y = m_ys; end
      else if (c == 'h80) m_en = 0;
      else m_idx = c;
   endtask

   task automatic send_byte(input int b);
      data_valid = 1'b1; data_byte = 8'(b);
      @(negedge clk);
      data_valid = 1'b0;
      model_byte(m_idx, b);
      m_idx = (m_idx + 1) & 'hFF;
   endtask

   // R2: whole setup loaded after one index command
   task automatic load_setup(input int xs, input int xe, input int ys, input int ye,
                             input int st, input int ba);
      send_cmd('h00);
      send_byte(xs >> 8); send_byte(xs & 'hFF);
      send_byte(xe >> 8); send_byte(xe & 'hFF);
      send_byte(ys >> 8); send_byte(ys & 'hFF);
      send_byte(ye >> 8); send_byte(ye & 'hFF);
      send_byte(st >> 8); send_byte(st & 'hFF);
      send_byte(ba >> 16); send_byte((ba >> 8) & 'hFF); send_byte(ba & 'hFF);
   endtask

   task automatic send_pix(input int d, input string req);
      int exp_a;
      pix_valid = 1'b1; pix_data = 18'(d);
      @(negedge clk);
      pix_valid = 1'b0;
      if (m_en) begin
         exp_a = (m_ba + m_y * m_st + m_x) & 'h3FFFF;
         check(ram_we === 1'b1, req, "R9 write enable", int'(ram_we), 1);
         check(ram_addr === 18'(exp_a), req, "address", int'(ram_addr), exp_a);
         check(ram_wdata === 18'(d), req, "R9 write data", int'(ram_wdata), d);
         if (m_x >= m_xe) begin
            m_x = m_xs;
            if (m_y >= m_ye) m_y = m_ys; else m_y++;
         end else m_x++;
      end else begin
         check(ram_we === 1'b0, req, "R8 ignored strobe", int'(ram_we), 0);
      end
   endtask

   initial begin
      #(5ns * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         report();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: no write after reset; default window then sweeps from address 0
      check(ram_we === 1'b0, "R1", "reset write enable", int'(ram_we), 0);
      send_pix('h15, "R8");
      send_cmd('hC1);
      for (int i = 0; i < 322; i++) send_pix(i * 7 + 3, "R1");

      // R3 R5 R6: small window, base near top of memory so the address wraps
      load_setup(2, 5, 1, 3, 10, 'h3FFF0);
      send_cmd('hC1);
      for (int i = 0; i < 25; i++) send_pix('h3FF00 + i, "R5");

      // R8: off mode ignores strobes; R7: re-entry homes the cursor
      send_cmd('h80);
      for (int i = 0; i < 3; i++) send_pix('h100 + i, "R8");
      send_cmd('hC1);
      for (int i = 0; i < 6; i++) send_pix('h200 + i, "R7");
      send_cmd('hC1);
      send_pix('h2AA, "R7");

      // R10: bytes above 0x0C change nothing, index wraps 0xFF -> 0x00
      // R3: high bytes keep only bits 1:0 (0xFD -> 1, 0xFE -> 2)
      send_cmd('h0D);
      send_byte('h55);
      send_cmd('hFF);
      send_byte('h77);
      send_byte('hFD); send_byte('h03);
      send_byte('hFE); send_byte('h00);
      send_byte('h00); send_byte('h00);
      send_byte('h00); send_byte('h01);
      send_byte('hFF); send_byte('hFF);
      send_byte('hFC); send_byte('h00); send_byte('h00);
      send_cmd('hC1);
      for (int i = 0; i < 258; i++) send_pix(i, "R10");

      // R4 R6: sweep of window shapes and strides over two passes each
      for (int w = 1; w <= 3; w++) begin
         for (int h = 1; h <= 3; h++) begin
            load_setup(w, 2 * w - 1 + 1, h, 2 * h, 7 + w, w * 1000 + h);
            send_cmd('hC1);
            for (int i = 0; i < 2 * (w + 1) * (h + 1) + 1; i++)
               send_pix(w * 64 + h * 8 + i, "R4");
         end
      end

      done = 1;
      report();
   end
endmodule